// File: doc/BRIEF.md
# Falling-Edge Watchdog with Selectable Period

This block watches a host's chip-select line, used here as a watchdog kick, and requests a system reset when that line shows no new HIGH-to-LOW transition within a chosen period. It runs on a system clock and counts a prescaled timebase tick supplied from outside. The period comes from a 2-bit code held in a configuration register. Three codes pick a long, a middle or a short period. The fourth code turns the watchdog off.

The kick line is asynchronous. It passes through a two-flop synchronizer and then a pulse-width filter before its edges are used. Only a falling edge restarts the count. A line that stays high or stays low therefore times out. A timeout raises a one-clock pulse and a reset request. The request is stretched over a fixed number of ticks. Kicks are ignored during that interval, and the count starts again from zero when the request is released. All periods are given as tick counts through parameters, so a short test setup can use small values.

Top module: `cs_watchdog`

## Requirements
- R1: With code 2'b00, 2'b01 or 2'b10 applied, the reset request rises on the P_LONG-th, P_MID-th or P_SHORT-th tick after the last restart, respectively, and not on any earlier tick.
- R2: A filtered HIGH-to-LOW transition of the kick line restarts the count from zero. A LOW-to-HIGH transition does not restart it.
- R3: A kick line held constantly high, or constantly low, leads to a timeout after the selected period.
- R4: Code 2'b11 disables the watchdog: no timeout occurs for any number of ticks, and the count is held at zero.
- R5: `timeout_pulse` is high for exactly one clock, in the same cycle that `reset_req` first goes high.
- R6: After a timeout, `reset_req` stays high for RST_TICKS ticks and falls on the RST_TICKS-th tick.
- R7: Kicks arriving while `reset_req` is high have no effect on its length. After release, the count restarts from zero, so the next timeout needs the full period.
- R8: Any change of the period code reloads the count from zero, including a change out of the disabled code.
- R9: The kick line is synchronized by two flops. A level held for fewer than MIN_PULSE clocks is ignored, so a short low glitch is not a restart.
- R10: While `rst_n` is low and after it is released, `reset_req` and `timeout_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock timebase tick from the prescaler |
| kick_in | input | 1 | Asynchronous chip-select / kick line |
| period_sel | input | 2 | Period code: 00 long, 01 mid, 10 short, 11 off |
| timeout_pulse | output | 1 | One-clock pulse at each timeout |
| reset_req | output | 1 | Reset request, held for the reset interval |

## Verification
The bench targets the exact tick on which each period expires. A count that is off by one would fire one tick early or one tick late, and the paired vectors at limit-1 and at limit would catch that. It drives a rising-only transition and a one-clock low glitch; a design that restarted on either edge, or that skipped the filter, would stay out of reset when it should have timed out. It sends a kick during the reset interval and changes the code mid-count. A design that let the kick shorten the interval, or that kept the old count across the code change, would time out at the wrong tick.

// File: rtl/cs_watchdog.sv
module cs_watchdog #(
  parameter int P_LONG    = 1400,
  parameter int P_MID     = 600,
  parameter int P_SHORT   = 200,
  parameter int RST_TICKS = 200,
  parameter int MIN_PULSE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       kick_in,
  input  logic [1:0] period_sel,
  output logic       timeout_pulse,
  output logic       reset_req
);

  localparam int PMAX = (P_LONG > P_MID) ? ((P_LONG > P_SHORT) ? P_LONG : P_SHORT)
                                         : ((P_MID > P_SHORT) ? P_MID : P_SHORT);
  localparam int CW = $clog2(PMAX + 1);
  localparam int RW = $clog2(RST_TICKS + 1);
  localparam int FW = $clog2(MIN_PULSE + 1);

  logic          ks1, ks2, kf;
  logic [FW-1:0] fcnt;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;
  logic [1:0]    sel_q;
  logic [CW-1:0] limit;
  logic          accept, kick_fall, off;

  assign accept    = (ks2 != kf) && (fcnt == FW'(MIN_PULSE - 1));
  assign kick_fall = accept && kf;
  assign off       = (period_sel == 2'b11);

  always_comb begin
    case (period_sel)
      2'b00:   limit = CW'(P_LONG);
      2'b01:   limit = CW'(P_MID);
      default: limit = CW'(P_SHORT);
    endcase
  end

  // kick synchronizer and width filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ks1  <= 1'b1;
      ks2  <= 1'b1;
      kf   <= 1'b1;
      fcnt <= '0;
    end else begin
      ks1 <= kick_in;
      ks2 <= ks1;
      if (ks2 == kf) fcnt <= '0;
      else if (accept) begin
        kf   <= ks2;
        fcnt <= '0;
      end else fcnt <= fcnt + FW'(1);
    end
  end

  // timeout counter and reset stretcher
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      rcnt          <= '0;
      sel_q         <= 2'b11;
      reset_req     <= 1'b0;
      timeout_pulse <= 1'b0;
    end else begin
      sel_q         <= period_sel;
      timeout_pulse <= 1'b0;
      if (reset_req) begin
        if (tick) begin
          if (rcnt == RW'(RST_TICKS - 1)) begin
            reset_req <= 1'b0;
            rcnt      <= '0;
            cnt       <= '0;
          end else rcnt <= rcnt + RW'(1);
        end
      end else if (off || period_sel != sel_q || kick_fall) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == limit - CW'(1)) begin
          cnt           <= '0;
          rcnt          <= '0;
          reset_req     <= 1'b1;
          timeout_pulse <= 1'b1;
        end else cnt <= cnt + CW'(1);
      end
    end
  end

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  p_pulse_with_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> $rose(reset_req));

  p_off_no_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (off && !reset_req) |=> !timeout_pulse);

  p_release_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req && !tick) |=> reset_req);

  p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !timeout_pulse);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!reset_req && !off && period_sel == sel_q) |-> (cnt < limit));

  p_stretch_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt < RW'(RST_TICKS));

endmodule

// File: tb/tb_cs_watchdog.sv
module tb_cs_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int PL = 12, PM = 6, PS = 3, RT = 4, MP = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, kick_in = 1'b1;
  logic [1:0] period_sel = 2'b11;
  logic timeout_pulse, reset_req;
  int checks = 0, fails = 0;
  bit done = 0;

  // {code, idle ticks, expect timeout}
  localparam logic [8:0] VEC [7] = '{
    {2'd0, 6'd11, 1'b0}, {2'd0, 6'd12, 1'b1},
    {2'd1, 6'd5,  1'b0}, {2'd1, 6'd6,  1'b1},
    {2'd2, 6'd2,  1'b0}, {2'd2, 6'd3,  1'b1},
    {2'd3, 6'd20, 1'b0}
  };

  cs_watchdog #(.P_LONG(PL), .P_MID(PM), .P_SHORT(PS), .RST_TICKS(RT), .MIN_PULSE(MP)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick_in(kick_in), .period_sel(period_sel),
    .timeout_pulse(timeout_pulse), .reset_req(reset_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic kick();
    kick_in = 1'b1; wait_clk(6);
    kick_in = 1'b0; wait_clk(6);
  endtask

  task automatic set_sel(input logic [1:0] s);
    @(negedge clk) period_sel = s;
    wait_clk(2);
  endtask

  task automatic finish_reset(input string req);
    do_tick(RT - 1);
    chk(req, reset_req, 1'b1);
    do_tick(1);
    chk(req, reset_req, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    chk("R10 reset_req in reset", reset_req, 1'b0);
    chk("R10 pulse in reset", timeout_pulse, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    wait_clk(3);
    chk("R10 reset_req after reset", reset_req, 1'b0);

    // table walk: R1 periods, R3 stuck-low, R4 disabled, R5, R6
    for (int i = 0; i < 7; i++) begin
      set_sel(VEC[i][8:7]);
      kick();
      do_tick(int'(VEC[i][6:1]));
      chk("R1/R3/R4 timeout at period", reset_req, VEC[i][0]);
      chk("R5 pulse with timeout", timeout_pulse, VEC[i][0]);
      if (VEC[i][0]) begin
        wait_clk(1);
        chk("R5 pulse one clock", timeout_pulse, 1'b0);
        finish_reset("R6 reset interval");
      end
    end

    // R3 stuck high; R8 leaving disabled reloads
    kick_in = 1'b1;
    set_sel(2'd2);
    do_tick(PS - 1);
    chk("R3 stuck high before period", reset_req, 1'b0);
    do_tick(1);
    chk("R3 stuck high timeout", reset_req, 1'b1);
    finish_reset("R6 reset interval");

    // R2 falling kick restarts mid-count
    set_sel(2'd1); set_sel(2'd2);
    do_tick(PS - 1);
    kick();
    do_tick(PS - 1);
    chk("R2 falling edge restarted", reset_req, 1'b0);
    do_tick(1);
    chk("R2 timeout after restart", reset_req, 1'b1);
    finish_reset("R6 reset interval");

    // R2 rising edge alone does not restart
    set_sel(2'd1); set_sel(2'd2);
    do_tick(PS - 1);
    kick_in = 1'b1; wait_clk(8);
    do_tick(1);
    chk("R2 rising edge no restart", reset_req, 1'b1);
    finish_reset("R6 reset interval");

    // R9 short low glitch ignored
    set_sel(2'd1); set_sel(2'd2);
    do_tick(PS - 1);
    @(negedge clk) kick_in = 1'b0;
    @(negedge clk) kick_in = 1'b1;
    wait_clk(8);
    do_tick(1);
    chk("R9 glitch ignored", reset_req, 1'b1);

    // R7 kick during reset interval ignored, then full period
    kick();
    do_tick(RT - 1);
    chk("R7 reset held despite kick", reset_req, 1'b1);
    do_tick(1);
    chk("R7 released on schedule", reset_req, 1'b0);
    do_tick(PS - 1);
    chk("R7 count from zero after release", reset_req, 1'b0);
    do_tick(1);
    chk("R7 timeout full period", reset_req, 1'b1);
    finish_reset("R6 reset interval");

    // R8 code change mid-count reloads
    set_sel(2'd0);
    kick();
    do_tick(PL - 2);
    set_sel(2'd1);
    do_tick(PM - 1);
    chk("R8 reload after code change", reset_req, 1'b0);
    do_tick(1);
    chk("R8 timeout new period", reset_req, 1'b1);
    finish_reset("R6 reset interval");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule